// File: doc/BRIEF.md
# Register-Mapped GPIO Port with Pin Interrupts

This block is a general-purpose I/O port for up to 31 pins. Software uses a simple synchronous word bus to control it. Each pin has three controls:

- a direction bit;
- an output level, which changes only through two atomic ports: writing ones to one port raises the selected pins, and writing ones to the other lowers them;
- a synchronized input level, which software can read back.

Each pin can also be an interrupt source. Every source has a type bit that chooses edge or level detection, and a polarity bit that chooses high/rising or low/falling. An enable bit arms detection. A separate mask bit gates the pin's path to the single shared interrupt line.

Pad inputs pass through a two-flop synchronizer, and edge and level detection both work on the synchronized value. A pending bit for an edge source is sticky until software acknowledges it. A pending bit for a level source follows the qualified level. Software reads the pending word to find which pins need service.

A build parameter chooses the sense of the direction register. Register bits at and above the pin count read as zero.

Top module: `pio_irq_ctrl`

## Requirements
- R1: After reset every pin is an input (`pad_oe` all 0), `pad_out` is 0, `irq` is 0, and the direction register reads back its input value (0 in the default active-high build). The enable, type, polarity, mask and pending registers all read 0.
- R2: A write to the set port at byte offset 0x0C drives `pad_out` high for every bit written as 1. Bits written as 0 keep their level.
- R3: A write to the clear port at byte offset 0x10 drives `pad_out` low for every bit written as 1. Bits written as 0 keep their level.
- R4: The direction register at offset 0x00 is read/write. When `DIR_ACTIVE_LOW`=0, a 1 makes the pin an output (`pad_oe`=1). When `DIR_ACTIVE_LOW`=1, a 1 makes the pin an input.
- R5: The input register at offset 0x04 returns the pad levels once they have passed two synchronizer flops. A pad change is visible there after at most three clock edges.
- R6: A pin whose type bit (offset 0x18) is 0 is edge-sensitive. If its polarity bit (offset 0x1C) is 1 it detects rising edges; if 0, falling edges. A detected edge sets its bit in the pending register (offset 0x20). That bit stays set until a 1 is written to it at offset 0x20; writing 0 leaves it unchanged.
- R7: A pin whose type bit is 1 is level-sensitive. Its pending bit is 1 exactly while its enable bit is 1 and the synchronized level equals its polarity bit. Writing to offset 0x20 does not clear it.
- R8: Edges that occur while a pin's enable bit (offset 0x14) is 0 are not detected, and setting the enable bit later does not create a pending bit for them.
- R9: `irq` is a registered copy of the OR over all pins of pending AND enable AND mask (mask at offset 0x24). A masked pin keeps its pending bit but does not raise `irq`.
- R10: Register bits at and above `NUM_PINS` read as 0 and ignore writes. Offsets not listed above read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |
| pad_in | input | NUM_PINS | Pad input levels (asynchronous) |
| pad_out | output | NUM_PINS | Pad output levels |
| pad_oe | output | NUM_PINS | Pad output enables, 1 = drive |
| irq | output | 1 | Combined interrupt request |

## Verification
The set and clear ports are tried with disjoint patterns, overlapping patterns and an all-zero word. These show whether zero bits really leave pins alone and whether set and clear stay independent.

Interrupt detection is tried with three kinds of stimulus:
- a rising edge on one pin and a falling edge on another, which separates the two polarities in edge mode;
- a rising edge on a disabled pin that is enabled afterwards, which shows whether edges are qualified by enable;
- a level held across acknowledge writes and then removed, which separates sticky edge pending bits from level pending bits that follow the pin.

Toggling the mask and the enable while a level source is active shows the difference between a pending bit and its contribution to `irq`. Writing all ones to every field shows whether register bits beyond the pin count exist.

// File: rtl/pio_irq_pkg.sv
package pio_irq_pkg;
   localparam int          PIO_DATA_W   = 32;
   localparam logic [7:0]  OFF_DIR      = 8'h00;
   localparam logic [7:0]  OFF_LEVEL    = 8'h04;
   localparam logic [7:0]  OFF_SET      = 8'h0C;
   localparam logic [7:0]  OFF_CLR      = 8'h10;
   localparam logic [7:0]  OFF_IEN      = 8'h14;
   localparam logic [7:0]  OFF_ITYPE    = 8'h18;
   localparam logic [7:0]  OFF_IPOL     = 8'h1C;
   localparam logic [7:0]  OFF_IPEND    = 8'h20;
   localparam logic [7:0]  OFF_IMASK    = 8'h24;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= {stg_q[STAGES-2:0], d};
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pio_pin_irq.sv
module pio_pin_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic enable,
   input  logic level_mode,
   input  logic active_high,
   input  logic ack,
   output logic pending
);
   logic prev_q;
   logic sticky_q;
   logic rise, fall, edge_hit, level_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign rise      = lvl & ~prev_q;
   assign fall      = ~lvl & prev_q;
   assign edge_hit  = enable & ~level_mode & (active_high ? rise : fall);
   assign level_hit = enable & level_mode & (lvl == active_high);

   // new edge wins over a simultaneous acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sticky_q <= 1'b0;
      else if (edge_hit) sticky_q <= 1'b1;
      else if (ack)      sticky_q <= 1'b0;
   end

   assign pending = level_mode ? level_hit : sticky_q;
endmodule

// File: rtl/pio_irq_ctrl.sv
module pio_irq_ctrl
   import pio_irq_pkg::*;
#(
   parameter int NUM_PINS       = 24,
   parameter bit DIR_ACTIVE_LOW = 1'b0,
   parameter int ADDR_W         = 6,
   parameter int SYNC_STAGES    = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel,
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [PIO_DATA_W-1:0] bus_wdata,
   output logic [PIO_DATA_W-1:0] bus_rdata,
   input  logic [NUM_PINS-1:0]   pad_in,
   output logic [NUM_PINS-1:0]   pad_out,
   output logic [NUM_PINS-1:0]   pad_oe,
   output logic                  irq
);
   localparam logic [NUM_PINS-1:0] DIR_RST = DIR_ACTIVE_LOW ? {NUM_PINS{1'b1}} : '0;

   if (NUM_PINS < 1 || NUM_PINS > 31) begin : g_bad_pins
      $error("pio_irq_ctrl: NUM_PINS must be in 1..31");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("pio_irq_ctrl: ADDR_W must be at least 6");
   end

   logic [NUM_PINS-1:0] dir_q, out_q, ien_q, ityp_q, ipol_q, imsk_q;
   logic [NUM_PINS-1:0] pin_lvl, pend_vec, wd;
   logic                irq_q;
   logic                wen;
   logic                we_dir, we_set, we_clr, we_ien, we_ityp, we_ipol, we_pend, we_imsk;
   logic                unused_wd_hi;

   assign wd           = bus_wdata[NUM_PINS-1:0];
   assign unused_wd_hi = ^bus_wdata[PIO_DATA_W-1:NUM_PINS];
   assign wen          = bus_sel & bus_wr;

   assign we_dir  = wen && (bus_addr == ADDR_W'(OFF_DIR));
   assign we_set  = wen && (bus_addr == ADDR_W'(OFF_SET));
   assign we_clr  = wen && (bus_addr == ADDR_W'(OFF_CLR));
   assign we_ien  = wen && (bus_addr == ADDR_W'(OFF_IEN));
   assign we_ityp = wen && (bus_addr == ADDR_W'(OFF_ITYPE));
   assign we_ipol = wen && (bus_addr == ADDR_W'(OFF_IPOL));
   assign we_pend = wen && (bus_addr == ADDR_W'(OFF_IPEND));
   assign we_imsk = wen && (bus_addr == ADDR_W'(OFF_IMASK));

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= DIR_RST;
         out_q  <= '0;
         ien_q  <= '0;
         ityp_q <= '0;
         ipol_q <= '0;
         imsk_q <= '0;
      end else begin
         if (we_dir)  dir_q  <= wd;
         if (we_ien)  ien_q  <= wd;
         if (we_ityp) ityp_q <= wd;
         if (we_ipol) ipol_q <= wd;
         if (we_imsk) imsk_q <= wd;
         out_q <= (out_q | (we_set ? wd : '0)) & ~(we_clr ? wd : '0);
      end
   end

   // direction sense chosen at build time
   if (DIR_ACTIVE_LOW) begin : g_dir_low
      assign pad_oe = ~dir_q;
   end else begin : g_dir_high
      assign pad_oe = dir_q;
   end
   assign pad_out = out_q;

   pio_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_lvl)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      pio_pin_irq u_pin (
         .clk         (clk),
         .rst_n       (rst_n),
         .lvl         (pin_lvl[i]),
         .enable      (ien_q[i]),
         .level_mode  (ityp_q[i]),
         .active_high (ipol_q[i]),
         .ack         (we_pend & wd[i]),
         .pending     (pend_vec[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(pend_vec & ien_q & imsk_q);
   end
   assign irq = irq_q;

   // read path
   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         unique case (bus_addr)
            ADDR_W'(OFF_DIR):   bus_rdata = PIO_DATA_W'(dir_q);
            ADDR_W'(OFF_LEVEL): bus_rdata = PIO_DATA_W'(pin_lvl);
            ADDR_W'(OFF_IEN):   bus_rdata = PIO_DATA_W'(ien_q);
            ADDR_W'(OFF_ITYPE): bus_rdata = PIO_DATA_W'(ityp_q);
            ADDR_W'(OFF_IPOL):  bus_rdata = PIO_DATA_W'(ipol_q);
            ADDR_W'(OFF_IPEND): bus_rdata = PIO_DATA_W'(pend_vec);
            ADDR_W'(OFF_IMASK): bus_rdata = PIO_DATA_W'(imsk_q);
            default:            bus_rdata = '0;
         endcase
      end
   end
endmodule

module pio_irq_ctrl_chk
   import pio_irq_pkg::*;
#(
   parameter int NUM_PINS = 24,
   parameter int ADDR_W   = 6
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           bus_sel,
   input logic                           bus_wr,
   input logic [ADDR_W-1:0]              bus_addr,
   input logic [NUM_PINS-1:0]            wd,
   input logic [PIO_DATA_W-1:NUM_PINS]   rd_hi,
   input logic [NUM_PINS-1:0]            pad_out,
   input logic                           irq,
   input logic [NUM_PINS-1:0]            ien,
   input logic [NUM_PINS-1:0]            imsk,
   input logic [NUM_PINS-1:0]            ityp,
   input logic [NUM_PINS-1:0]            pend
);
   logic wr_set, wr_clr, wr_pend;
   assign wr_set  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_SET));
   assign wr_clr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_CLR));
   assign wr_pend = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_IPEND));

   AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((pad_out & $past(wd)) == $past(wd))); // R2

   AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((pad_out & $past(wd)) == '0)); // R3

   AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(pend & ~ityp) & ~pend & ~ityp & ~$past(ityp))) |-> $past(wr_pend)); // R6

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      ((ien & imsk) == '0) |=> !irq); // R9

   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(|(pend & ien & imsk))); // R9

   AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hi == '0); // R10
endmodule

bind pio_irq_ctrl pio_irq_ctrl_chk #(
   .NUM_PINS (NUM_PINS),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_sel  (bus_sel),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .wd       (bus_wdata[NUM_PINS-1:0]),
   .rd_hi    (bus_rdata[31:NUM_PINS]),
   .pad_out  (pad_out),
   .irq      (irq),
   .ien      (ien_q),
   .imsk     (imsk_q),
   .ityp     (ityp_q),
   .pend     (pend_vec)
);

// File: tb/tb_pio_irq_ctrl.sv
module tb_pio_irq_ctrl;
   localparam int NP = 24;
   localparam int AW = 6;
   localparam logic [31:0] PMASK = 32'h00FF_FFFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out, pad_oe;
   logic          irq;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   pio_irq_ctrl #(.NUM_PINS(NP), .DIR_ACTIVE_LOW(1'b0), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      chk("R1 pad_oe", 32'(pad_oe), 0);
      chk("R1 pad_out", 32'(pad_out), 0);
      chk("R1 irq", 32'(irq), 0);
      rd(8'h00, v); chk("R1 dir", v, 0);
      rd(8'h14, v); chk("R1 ien", v, 0);
      rd(8'h20, v); chk("R1 pend", v, 0);
   endtask

   task automatic t_dir;
      logic [31:0] v;
      wr(8'h00, 32'h00FF_00F0);
      chk("R4 pad_oe", 32'(pad_oe), 32'h00FF_00F0);
      rd(8'h00, v); chk("R4 dir readback", v, 32'h00FF_00F0);
   endtask

   task automatic t_setclr;
      wr(8'h0C, 32'h0000_0F0F); chk("R2 set1", 32'(pad_out), 32'h0000_0F0F);
      wr(8'h0C, 32'h00F0_0003); chk("R2 set2", 32'(pad_out), 32'h00F0_0F0F);
      wr(8'h10, 32'h0000_0F01); chk("R3 clr1", 32'(pad_out), 32'h00F0_000E);
      wr(8'h10, 32'h0000_0000); chk("R3 clr0", 32'(pad_out), 32'h00F0_000E);
      wr(8'h0C, 32'h0000_0000); chk("R2 set0", 32'(pad_out), 32'h00F0_000E);
   endtask

   task automatic t_high;
      logic [31:0] v;
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, v); chk("R10 dir upper", v, PMASK);
      wr(8'h24, 32'hFF00_0000);
      rd(8'h24, v); chk("R10 mask upper", v, 0);
      rd(8'h08, v); chk("R10 hole 08", v, 0);
      rd(8'h28, v); chk("R10 hole 28", v, 0);
      wr(8'h00, 32'h0);
   endtask

   task automatic t_input;
      logic [31:0] v;
      @(negedge clk); pad_in = 24'hA5A5A5;
      idle(3);
      rd(8'h04, v); chk("R5 level", v, 32'h00A5_A5A5);
      @(negedge clk); pad_in = 24'h000002;
      idle(4);
      rd(8'h04, v); chk("R5 level2", v, 32'h0000_0002);
   endtask

   task automatic t_edge;
      logic [31:0] v;
      wr(8'h18, 32'h0);
      wr(8'h1C, 32'h0000_0005);      // bit0 rising, bit1 falling, bit2 rising
      wr(8'h24, 32'h0000_000F);
      wr(8'h14, 32'h0000_0003);
      wr(8'h20, 32'hFFFF_FFFF);
      rd(8'h20, v); chk("R6 pend clear", v, 0);
      @(negedge clk); pad_in = 24'h000003;   // rising bit0
      idle(5);
      rd(8'h20, v); chk("R6 rising pend", v, 32'h1);
      chk("R9 irq edge", 32'(irq), 1);
      wr(8'h20, 32'h0000_0002);
      rd(8'h20, v); chk("R6 ack other bit", v, 32'h1);
      wr(8'h20, 32'h0000_0001);
      idle(2);
      rd(8'h20, v); chk("R6 ack", v, 0);
      chk("R9 irq after ack", 32'(irq), 0);
      @(negedge clk); pad_in = 24'h000001;   // falling bit1
      idle(5);
      rd(8'h20, v); chk("R6 falling pend", v, 32'h2);
      @(negedge clk); pad_in = 24'h000003;   // rising bit1: wrong polarity
      idle(5);
      wr(8'h20, 32'h2);
      rd(8'h20, v); chk("R6 opposite edge", v, 0);
      @(negedge clk); pad_in = 24'h000001;
      idle(5);
      wr(8'h20, 32'h2);
   endtask

   task automatic t_disabled;
      logic [31:0] v;
      @(negedge clk); pad_in = 24'h000005;   // rising bit2, not enabled
      idle(5);
      rd(8'h20, v); chk("R8 no pend while disabled", v, 0);
      wr(8'h14, 32'h0000_0007);
      idle(3);
      rd(8'h20, v); chk("R8 no pend after enable", v, 0);
      chk("R8 irq", 32'(irq), 0);
   endtask

   task automatic t_level;
      logic [31:0] v;
      wr(8'h18, 32'h0000_0008);
      wr(8'h1C, 32'h0000_000D);
      wr(8'h14, 32'h0000_000F);
      rd(8'h20, v); chk("R7 level inactive", v, 0);
      @(negedge clk); pad_in = 24'h00000D;
      idle(5);
      rd(8'h20, v); chk("R7 level active", v, 32'h8);
      chk("R9 irq level", 32'(irq), 1);
      wr(8'h20, 32'hFFFF_FFFF);
      rd(8'h20, v); chk("R7 no ack on level", v, 32'h8);
      wr(8'h24, 32'h0000_0007);
      idle(2);
      chk("R9 masked irq", 32'(irq), 0);
      rd(8'h20, v); chk("R9 masked pend kept", v, 32'h8);
      wr(8'h24, 32'h0000_000F);
      idle(2);
      chk("R9 unmasked irq", 32'(irq), 1);
      wr(8'h14, 32'h0000_0007);
      idle(2);
      chk("R9 disabled irq", 32'(irq), 0);
      rd(8'h20, v); chk("R7 disabled level", v, 0);
      wr(8'h14, 32'h0000_000F);
      @(negedge clk); pad_in = 24'h000005;
      idle(5);
      rd(8'h20, v); chk("R7 level removed", v, 0);
      chk("R7 irq removed", 32'(irq), 0);
   endtask

   initial begin
      idle(3);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_dir();
      t_setclr();
      t_high();
      t_input();
      t_edge();
      t_disabled();
      t_level();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule